// File: doc/BRIEF.md
# Software-Managed Paired-Page Translation Buffer

This block is a fully associative address-translation cache. Software fills and maintains every slot. Each slot maps one virtual page pair, that is an even page and an odd page, to two physical frames. Each frame has its own cache attribute, dirty bit and valid bit. A slot also holds an address-space tag, a global flag and a per-slot size mask. The size mask removes low virtual-page bits from the compare, so one slot can cover a larger region.

Four views of the table are offered:
- a lookup port, which gives a combinational translation and a registered hit/miss one cycle later;
- a probe port, which returns the index of the matching slot;
- an indexed read/write port, which works on packed register images;
- a flush command, which empties the table.

The block also keeps a next-slot replacement pointer that software can step. Two small helpers sit beside the table: one flags uncacheable virtual addresses, and one decodes the privilege mode from a processor status word.

Top module: `ptlb_top`

## Requirements
- R1: Write and read images share one layout. In a low image the frame number starts at bit 6, the cache attribute is in bits 5:3, dirty in bit 2, valid in bit 1 and global in bit 0. The high image is (VPN << 11) | ASID. The mask image is mask << 11. The stored global flag is bit 0 of the even image AND bit 0 of the odd image, and it reads back in bit 0 of both low images.
- R2: A slot matches when the lookup VPN (vaddr[31:13]) equals the stored VPN in every bit where the slot's mask is 0. Bits where the mask is 1 are ignored.
- R3: If the global flag is set, the tag compare is skipped. Otherwise the incoming ASID must equal the stored ASID.
- R4: A slot takes part in matching only while at least one of its two valid bits is 1. Writing a slot replaces all of its previous contents.
- R5: The probe returns the lowest matching index. On a miss it returns all ones (-1).
- R6: The page half is chosen by vaddr bit 12+T, where T is the number of trailing ones in the mask (0 = even, 1 = odd). If that half is valid, lu_hit is high and lu_pfn, lu_attr and lu_dirty come from it. If that half is not valid, lu_inval is high, lu_hit is low, and the translation outputs are 0.
- R7: When more than one slot matches, the lowest index supplies the result and lu_multi is high.
- R8: The cycle after lu_req is high, lu_hit_q equals that cycle's lu_hit and lu_miss_q equals its inverse. Both are low after a cycle without lu_req.
- R9: A write to an index of ENTRIES or above changes no slot.
- R10: Flush clears every slot to zero and sets the replacement pointer to 0. It overrides a write in the same cycle.
- R11: Each rp_adv pulse steps the pointer by one, and the pointer wraps from ENTRIES-1 to 0.
- R12: lu_uncached is high exactly when vaddr bits 31 and 29 are both 1.
- R13: mode reads 00 (kernel) when status bit 28, 2 or 1 is set, or when status[4:3] is 00. Otherwise it reads 01 (supervisor) for 01, 10 (user) for 10, and 11 (invalid) for 11.
- R14: After reset every slot reads zero, the pointer is 0 and the registered outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lu_req | input | 1 | Lookup request qualifier for the registered result |
| lu_vaddr | input | VA_W | Lookup virtual address |
| lu_asid | input | ASID_W | Lookup address-space tag |
| lu_hit | output | 1 | Combinational valid translation |
| lu_inval | output | 1 | Slot matched but the selected half is invalid |
| lu_multi | output | 1 | More than one slot matched |
| lu_pfn | output | PFN_W | Translated frame number |
| lu_attr | output | 3 | Cache attribute of the selected half |
| lu_dirty | output | 1 | Dirty bit of the selected half |
| lu_uncached | output | 1 | Address lies in the uncacheable window |
| lu_hit_q | output | 1 | Registered hit |
| lu_miss_q | output | 1 | Registered miss |
| pr_vpn | input | VPN_W | Probe page number |
| pr_asid | input | ASID_W | Probe tag |
| pr_index | output | AIDX_W | Matching index, or -1 |
| wr_en | input | 1 | Indexed write strobe |
| wr_index | input | AIDX_W | Write slot index |
| wr_hi | input | HI_W | High image to write |
| wr_pmask | input | HI_W | Mask image to write |
| wr_lo0 | input | LO_W | Even-page image to write |
| wr_lo1 | input | LO_W | Odd-page image to write |
| rd_index | input | AIDX_W | Read slot index |
| rd_hi | output | HI_W | High image read back |
| rd_pmask | output | HI_W | Mask image read back |
| rd_lo0 | output | LO_W | Even-page image read back |
| rd_lo1 | output | LO_W | Odd-page image read back |
| flush | input | 1 | Clear the whole table |
| rp_adv | input | 1 | Step the replacement pointer |
| rp_index | output | IDX_W | Replacement pointer |
| status | input | 32 | Processor status word |
| mode | output | 2 | Decoded privilege mode |

## Verification
A corrupted slot shows up on the very next combinational lookup or probe that addresses it. It shows as a wrong frame, a wrong index, a missing hit or a false multiple-match flag. A readback of that slot through the read port exposes it the same way, with no clock needed.

A wrong mask or global flag can stay hidden until an address inside the widened region, or one with a foreign tag, is presented. For that reason the vectors deliberately touch masked bits and mismatched tags. Pointer and registered-result faults appear one edge after the command that should have moved them.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
   typedef enum logic [1:0] {
      MODE_KERNEL = 2'b00,
      MODE_SUPER  = 2'b01,
      MODE_USER   = 2'b10,
      MODE_BAD    = 2'b11
   } prv_mode_e;

   localparam int ATTR_W      = 3;
   localparam int LO_G_BIT    = 0;
   localparam int LO_V_BIT    = 1;
   localparam int LO_D_BIT    = 2;
   localparam int LO_ATTR_LSB = 3;
   localparam int LO_PFN_LSB  = 6;
   localparam int HI_VPN_LSB  = 11;
endpackage

// File: rtl/ptlb_store.sv
module ptlb_store #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 19,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 20,
   parameter int ATTR_W  = 3,
   parameter int AIDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [AIDX_W-1:0] wr_index,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [VPN_W-1:0]  wr_mask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_g,
   input  logic [PFN_W-1:0]  wr_pfn [2],
   input  logic [ATTR_W-1:0] wr_attr [2],
   input  logic [1:0]        wr_d,
   input  logic [1:0]        wr_v,
   output logic [VPN_W-1:0]  e_vpn [ENTRIES],
   output logic [VPN_W-1:0]  e_mask [ENTRIES],
   output logic [ASID_W-1:0] e_asid [ENTRIES],
   output logic [ENTRIES-1:0] e_g,
   output logic [PFN_W-1:0]  e_pfn [ENTRIES][2],
   output logic [ATTR_W-1:0] e_attr [ENTRIES][2],
   output logic [1:0]        e_d [ENTRIES],
   output logic [1:0]        e_v [ENTRIES]
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            e_vpn[i]     <= '0;
            e_mask[i]    <= '0;
            e_asid[i]    <= '0;
            e_g[i]       <= 1'b0;
            e_pfn[i][0]  <= '0;
            e_pfn[i][1]  <= '0;
            e_attr[i][0] <= '0;
            e_attr[i][1] <= '0;
            e_d[i]       <= '0;
            e_v[i]       <= '0;
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (flush) begin
               e_vpn[i]     <= '0;
               e_mask[i]    <= '0;
               e_asid[i]    <= '0;
               e_g[i]       <= 1'b0;
               e_pfn[i][0]  <= '0;
               e_pfn[i][1]  <= '0;
               e_attr[i][0] <= '0;
               e_attr[i][1] <= '0;
               e_d[i]       <= '0;
               e_v[i]       <= '0;
            end else if (wr_en && (wr_index == AIDX_W'(i))) begin
               e_vpn[i]     <= wr_vpn;
               e_mask[i]    <= wr_mask;
               e_asid[i]    <= wr_asid;
               e_g[i]       <= wr_g;
               e_pfn[i][0]  <= wr_pfn[0];
               e_pfn[i][1]  <= wr_pfn[1];
               e_attr[i][0] <= wr_attr[0];
               e_attr[i][1] <= wr_attr[1];
               e_d[i]       <= wr_d;
               e_v[i]       <= wr_v;
            end
         end
      end
   end
endmodule

// File: rtl/ptlb_match.sv
module ptlb_match #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 19,
   parameter int ASID_W  = 8,
   parameter int IDX_W   = 4
) (
   input  logic [VPN_W-1:0]   q_vpn,
   input  logic [ASID_W-1:0]  q_asid,
   input  logic [VPN_W-1:0]   e_vpn [ENTRIES],
   input  logic [VPN_W-1:0]   e_mask [ENTRIES],
   input  logic [ASID_W-1:0]  e_asid [ENTRIES],
   input  logic [ENTRIES-1:0] e_g,
   input  logic [ENTRIES-1:0] e_live,
   output logic               any,
   output logic               multi,
   output logic [IDX_W-1:0]   idx
);
   logic [ENTRIES-1:0] hv;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hv[i] = e_live[i]
                   && (((q_vpn ^ e_vpn[i]) & ~e_mask[i]) == '0)
                   && (e_g[i] || (q_asid == e_asid[i]));
   end

   // lowest index wins: scan downward so the last hit written is the smallest
   always_comb begin
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hv[i]) idx = IDX_W'(i);
      end
   end

   assign any   = |hv;
   assign multi = $countones(hv) > 1;
endmodule

// File: rtl/ptlb_mode.sv
module ptlb_mode
   import ptlb_pkg::*;
(
   input  logic [31:0] status,
   input  logic [1:0]  uc_bits,
   output prv_mode_e   mode,
   output logic        uncached
);
   logic unused_st;
   assign unused_st = ^{status[31:29], status[27:5], status[0]};

   always_comb begin
      if (status[28] || status[2] || status[1]) begin
         mode = MODE_KERNEL;
      end else begin
         case (status[4:3])
            2'b00:   mode = MODE_KERNEL;
            2'b01:   mode = MODE_SUPER;
            2'b10:   mode = MODE_USER;
            default: mode = MODE_BAD;
         endcase
      end
   end

   assign uncached = &uc_bits;
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
   import ptlb_pkg::*;
#(
   parameter int ENTRIES  = 16,
   parameter int VA_W     = 32,
   parameter int PAGE_LSB = 12,
   parameter int ASID_W   = 8,
   parameter int PFN_W    = 20,
   localparam int VPN_W   = VA_W - PAGE_LSB - 1,
   localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int AIDX_W  = IDX_W + 1,
   localparam int LO_W    = PFN_W + LO_PFN_LSB,
   localparam int HI_W    = VPN_W + HI_VPN_LSB
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     lu_req,
   input  logic [VA_W-1:0]          lu_vaddr,
   input  logic [ASID_W-1:0]        lu_asid,
   output logic                     lu_hit,
   output logic                     lu_inval,
   output logic                     lu_multi,
   output logic [PFN_W-1:0]         lu_pfn,
   output logic [ATTR_W-1:0]        lu_attr,
   output logic                     lu_dirty,
   output logic                     lu_uncached,
   output logic                     lu_hit_q,
   output logic                     lu_miss_q,
   input  logic [VPN_W-1:0]         pr_vpn,
   input  logic [ASID_W-1:0]        pr_asid,
   output logic signed [AIDX_W-1:0] pr_index,
   input  logic                     wr_en,
   input  logic [AIDX_W-1:0]        wr_index,
   input  logic [HI_W-1:0]          wr_hi,
   input  logic [HI_W-1:0]          wr_pmask,
   input  logic [LO_W-1:0]          wr_lo0,
   input  logic [LO_W-1:0]          wr_lo1,
   input  logic [AIDX_W-1:0]        rd_index,
   output logic [HI_W-1:0]          rd_hi,
   output logic [HI_W-1:0]          rd_pmask,
   output logic [LO_W-1:0]          rd_lo0,
   output logic [LO_W-1:0]          rd_lo1,
   input  logic                     flush,
   input  logic                     rp_adv,
   output logic [IDX_W-1:0]         rp_index,
   input  logic [31:0]              status,
   output logic [1:0]               mode
);
   localparam int OW = $clog2(VPN_W + 1);

   if (ASID_W > HI_VPN_LSB - 1) begin : g_bad_asid
      $error("ASID_W must fit below the VPN field of the high image");
   end
   if (VA_W < PAGE_LSB + 4) begin : g_bad_va
      $error("VA_W too small for PAGE_LSB");
   end
   if (ENTRIES < 2) begin : g_bad_ent
      $error("ENTRIES must be at least 2");
   end

   // write image decode
   logic [VPN_W-1:0]  w_vpn, w_mask;
   logic [ASID_W-1:0] w_asid;
   logic [PFN_W-1:0]  w_pfn [2];
   logic [ATTR_W-1:0] w_attr [2];
   logic [1:0]        w_d, w_v;
   logic              unused_bits;

   assign w_vpn     = wr_hi[HI_W-1:HI_VPN_LSB];
   assign w_asid    = wr_hi[ASID_W-1:0];
   assign w_mask    = wr_pmask[HI_W-1:HI_VPN_LSB];
   assign w_pfn[0]  = wr_lo0[LO_W-1:LO_PFN_LSB];
   assign w_pfn[1]  = wr_lo1[LO_W-1:LO_PFN_LSB];
   assign w_attr[0] = wr_lo0[LO_ATTR_LSB +: ATTR_W];
   assign w_attr[1] = wr_lo1[LO_ATTR_LSB +: ATTR_W];
   assign w_d       = {wr_lo1[LO_D_BIT], wr_lo0[LO_D_BIT]};
   assign w_v       = {wr_lo1[LO_V_BIT], wr_lo0[LO_V_BIT]};
   assign unused_bits = ^{wr_hi[HI_VPN_LSB-1:ASID_W], wr_pmask[HI_VPN_LSB-1:0],
                          lu_vaddr[PAGE_LSB-1:0]};

   // table
   logic [VPN_W-1:0]   e_vpn [ENTRIES];
   logic [VPN_W-1:0]   e_mask [ENTRIES];
   logic [ASID_W-1:0]  e_asid [ENTRIES];
   logic [ENTRIES-1:0] e_g, e_live;
   logic [PFN_W-1:0]   e_pfn [ENTRIES][2];
   logic [ATTR_W-1:0]  e_attr [ENTRIES][2];
   logic [1:0]         e_d [ENTRIES];
   logic [1:0]         e_v [ENTRIES];

   ptlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W),
                .ATTR_W(ATTR_W), .AIDX_W(AIDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_index(wr_index),
      .wr_vpn(w_vpn), .wr_mask(w_mask), .wr_asid(w_asid),
      .wr_g(wr_lo0[LO_G_BIT] & wr_lo1[LO_G_BIT]),
      .wr_pfn(w_pfn), .wr_attr(w_attr), .wr_d(w_d), .wr_v(w_v),
      .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_g(e_g),
      .e_pfn(e_pfn), .e_attr(e_attr), .e_d(e_d), .e_v(e_v));

   for (genvar i = 0; i < ENTRIES; i++) begin : g_live
      assign e_live[i] = |e_v[i];
   end

   // lookup and probe share one comparator design
   logic             lu_any, pr_any;
   logic [IDX_W-1:0] lu_idx, pr_idx;
   logic             pr_multi;

   ptlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_lu_cmp (
      .q_vpn(lu_vaddr[VA_W-1:PAGE_LSB+1]), .q_asid(lu_asid),
      .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_g(e_g), .e_live(e_live),
      .any(lu_any), .multi(lu_multi), .idx(lu_idx));

   ptlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_pr_cmp (
      .q_vpn(pr_vpn), .q_asid(pr_asid),
      .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_g(e_g), .e_live(e_live),
      .any(pr_any), .multi(pr_multi), .idx(pr_idx));

   logic unused_prm;
   assign unused_prm = pr_multi;
   assign pr_index   = pr_any ? $signed({1'b0, pr_idx}) : '1;

   // even/odd half select: bit just above the masked page offset
   logic [OW-1:0] tz;
   logic          run;
   logic          half;
   logic          half_ok;

   always_comb begin
      tz  = '0;
      run = 1'b1;
      for (int b = 0; b < VPN_W; b++) begin
         if (run && e_mask[lu_idx][b]) tz = tz + 1'b1;
         else run = 1'b0;
      end
   end

   assign half    = lu_vaddr[PAGE_LSB + int'(tz)];
   assign half_ok = e_v[lu_idx][half];
   assign lu_hit   = lu_any && half_ok;
   assign lu_inval = lu_any && !half_ok;
   assign lu_pfn   = lu_hit ? e_pfn[lu_idx][half] : '0;
   assign lu_attr  = lu_hit ? e_attr[lu_idx][half] : '0;
   assign lu_dirty = lu_hit && e_d[lu_idx][half];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lu_hit_q  <= 1'b0;
         lu_miss_q <= 1'b0;
      end else begin
         lu_hit_q  <= lu_req && lu_hit;
         lu_miss_q <= lu_req && !lu_hit;
      end
   end

   // replacement pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rp_index <= '0;
      else if (flush)  rp_index <= '0;
      else if (rp_adv) rp_index <= (rp_index == IDX_W'(ENTRIES - 1)) ? '0 : rp_index + 1'b1;
   end

   // readback
   logic             rd_ok;
   logic [IDX_W-1:0] rs;

   assign rd_ok = rd_index < AIDX_W'(ENTRIES);
   assign rs    = rd_index[IDX_W-1:0];

   always_comb begin
      rd_hi    = '0;
      rd_pmask = '0;
      rd_lo0   = '0;
      rd_lo1   = '0;
      if (rd_ok) begin
         rd_hi    = {e_vpn[rs], {HI_VPN_LSB{1'b0}}} | HI_W'(e_asid[rs]);
         rd_pmask = {e_mask[rs], {HI_VPN_LSB{1'b0}}};
         rd_lo0   = {e_pfn[rs][0], e_attr[rs][0], e_d[rs][0], e_v[rs][0], e_g[rs]};
         rd_lo1   = {e_pfn[rs][1], e_attr[rs][1], e_d[rs][1], e_v[rs][1], e_g[rs]};
      end
   end

   // helpers
   prv_mode_e mode_e;
   ptlb_mode u_mode (
      .status(status), .uc_bits({lu_vaddr[VA_W-1], lu_vaddr[VA_W-3]}),
      .mode(mode_e), .uncached(lu_uncached));
   assign mode = mode_e;
endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int AIDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lu_req,
   input logic              lu_hit,
   input logic              lu_inval,
   input logic              lu_hit_q,
   input logic              lu_miss_q,
   input logic [AIDX_W-1:0] pr_index,
   input logic              flush,
   input logic              rp_adv,
   input logic [IDX_W-1:0]  rp_index,
   input logic [31:0]       status,
   input logic [1:0]        mode
);
   AST_HIT_INVAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(lu_hit && lu_inval)); // R6
   AST_PROBE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (pr_index == {AIDX_W{1'b1}}) || (pr_index < AIDX_W'(ENTRIES))); // R5
   AST_REG_RESULT: assert property (@(posedge clk) disable iff (!rst_n) lu_req |=> (lu_hit_q == $past(lu_hit)) && (lu_miss_q == !$past(lu_hit))); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !lu_req |=> !lu_hit_q && !lu_miss_q); // R8
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (rp_index == '0) && (pr_index == {AIDX_W{1'b1}}) && !lu_hit && !lu_inval); // R10
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (rp_adv && !flush) |=> rp_index == (($past(rp_index) == IDX_W'(ENTRIES - 1)) ? '0 : IDX_W'($past(rp_index) + 1'b1))); // R11
   AST_MODE_KERNEL: assert property (@(posedge clk) disable iff (!rst_n) (status[28] || status[2] || status[1]) |-> mode == 2'b00); // R13
endmodule

bind ptlb_top ptlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .AIDX_W(AIDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lu_req(lu_req), .lu_hit(lu_hit), .lu_inval(lu_inval),
   .lu_hit_q(lu_hit_q), .lu_miss_q(lu_miss_q), .pr_index(pr_index), .flush(flush),
   .rp_adv(rp_adv), .rp_index(rp_index), .status(status), .mode(mode));

// File: tb/ptlb_top_test.sv
`timescale 1ns/1ps
module ptlb_top_test;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lu_req = 1'b0;
   logic [31:0]       lu_vaddr = '0;
   logic [7:0]        lu_asid = '0;
   logic              lu_hit, lu_inval, lu_multi, lu_dirty, lu_uncached, lu_hit_q, lu_miss_q;
   logic [19:0]       lu_pfn;
   logic [2:0]        lu_attr;
   logic [18:0]       pr_vpn = '0;
   logic [7:0]        pr_asid = '0;
   logic signed [4:0] pr_index;
   logic              wr_en = 1'b0;
   logic [4:0]        wr_index = '0;
   logic [29:0]       wr_hi = '0, wr_pmask = '0;
   logic [25:0]       wr_lo0 = '0, wr_lo1 = '0;
   logic [4:0]        rd_index = '0;
   logic [29:0]       rd_hi, rd_pmask;
   logic [25:0]       rd_lo0, rd_lo1;
   logic              flush = 1'b0, rp_adv = 1'b0;
   logic [3:0]        rp_index;
   logic [31:0]       status = '0;
   logic [1:0]        mode;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   ptlb_top uut (
      .clk(clk), .rst_n(rst_n), .lu_req(lu_req), .lu_vaddr(lu_vaddr), .lu_asid(lu_asid),
      .lu_hit(lu_hit), .lu_inval(lu_inval), .lu_multi(lu_multi), .lu_pfn(lu_pfn),
      .lu_attr(lu_attr), .lu_dirty(lu_dirty), .lu_uncached(lu_uncached),
      .lu_hit_q(lu_hit_q), .lu_miss_q(lu_miss_q), .pr_vpn(pr_vpn), .pr_asid(pr_asid),
      .pr_index(pr_index), .wr_en(wr_en), .wr_index(wr_index), .wr_hi(wr_hi),
      .wr_pmask(wr_pmask), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1), .rd_index(rd_index),
      .rd_hi(rd_hi), .rd_pmask(rd_pmask), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1),
      .flush(flush), .rp_adv(rp_adv), .rp_index(rp_index), .status(status), .mode(mode));

   function automatic logic [25:0] mk_lo(logic [19:0] pfn, logic [2:0] a, logic d, logic v, logic g);
      return {pfn, a, d, v, g};
   endfunction
   function automatic logic [29:0] mk_hi(logic [18:0] vpn, logic [7:0] asid);
      return {vpn, 11'h0} | {22'h0, asid};
   endfunction
   function automatic logic [29:0] mk_pm(logic [18:0] m);
      return {m, 11'h0};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // starts and ends at a falling edge
   task automatic put(input logic [4:0] idx, input logic [29:0] hi, input logic [29:0] pm,
                      input logic [25:0] lo0, input logic [25:0] lo1);
      wr_en = 1'b1; wr_index = idx; wr_hi = hi; wr_pmask = pm; wr_lo0 = lo0; wr_lo1 = lo1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic adv(input int n);
      for (int k = 0; k < n; k++) begin
         rp_adv = 1'b1;
         @(negedge clk);
      end
      rp_adv = 1'b0;
   endtask

   task automatic look(input logic [31:0] va, input logic [7:0] asid);
      lu_vaddr = va; lu_asid = asid; pr_vpn = va[31:13]; pr_asid = asid;
      #1;
   endtask

   typedef struct packed {
      logic [31:0] va;
      logic [7:0]  asid;
      logic        hit;
      logic        inval;
      logic        multi;
      logic [19:0] pfn;
      logic [4:0]  probe;
   } vec_t;

   localparam vec_t VEC [9] = '{
      '{32'h0002_0000, 8'd5,    1'b1, 1'b0, 1'b0, 20'h111, 5'd0},
      '{32'h0002_1000, 8'd5,    1'b0, 1'b1, 1'b0, 20'h000, 5'd0},
      '{32'h0002_0000, 8'd6,    1'b0, 1'b0, 1'b0, 20'h000, 5'h1F},
      '{32'h0004_1000, 8'd3,    1'b1, 1'b0, 1'b1, 20'h444, 5'd1},
      '{32'h0004_0000, 8'h77,   1'b1, 1'b0, 1'b1, 20'h333, 5'd1},
      '{32'h0020_4000, 8'd9,    1'b1, 1'b0, 1'b0, 20'h666, 5'd2},
      '{32'h0020_2000, 8'd9,    1'b1, 1'b0, 1'b0, 20'h555, 5'd2},
      '{32'h0020_8000, 8'd9,    1'b0, 1'b0, 1'b0, 20'h000, 5'h1F},
      '{32'h0006_0000, 8'd5,    1'b0, 1'b0, 1'b0, 20'h000, 5'h1F}
   };

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R14 reset state
      rd_index = 5'd0; look(32'h0, 8'h0);
      chk(rd_hi === 30'h0 && rd_lo0 === 26'h0 && rd_lo1 === 26'h0, "R14 slot0 empty", {rd_hi, rd_lo0}, 0);
      chk(rp_index === 4'd0, "R14 pointer", rp_index, 0);
      chk(!lu_hit_q && !lu_miss_q, "R14 regs low", {lu_hit_q, lu_miss_q}, 0);
      chk(pr_index === 5'h1F, "R14 R5 probe empty", pr_index, 5'h1F);

      put(5'd0, mk_hi(19'h10, 8'd5), mk_pm(19'h0), mk_lo(20'h111, 3'd3, 1, 1, 0), mk_lo(20'h222, 3'd2, 0, 0, 0));
      put(5'd1, mk_hi(19'h20, 8'd7), mk_pm(19'h0), mk_lo(20'h333, 3'd1, 0, 1, 1), mk_lo(20'h444, 3'd5, 1, 1, 1));
      put(5'd2, mk_hi(19'h100, 8'd9), mk_pm(19'h3), mk_lo(20'h555, 3'd0, 0, 1, 0), mk_lo(20'h666, 3'd4, 1, 1, 0));
      put(5'd3, mk_hi(19'h30, 8'd5), mk_pm(19'h0), mk_lo(20'h888, 3'd0, 0, 0, 1), mk_lo(20'h999, 3'd0, 0, 0, 0));
      put(5'd5, mk_hi(19'h20, 8'd0), mk_pm(19'h0), mk_lo(20'h777, 3'd0, 0, 1, 1), mk_lo(20'h0, 3'd0, 0, 0, 1));

      // R1 readback images
      rd_index = 5'd0; #1;
      chk(rd_lo0 === mk_lo(20'h111, 3'd3, 1, 1, 0), "R1 lo0", rd_lo0, mk_lo(20'h111, 3'd3, 1, 1, 0));
      chk(rd_hi === mk_hi(19'h10, 8'd5), "R1 hi", rd_hi, mk_hi(19'h10, 8'd5));
      rd_index = 5'd1; #1;
      chk(rd_lo1 === mk_lo(20'h444, 3'd5, 1, 1, 1), "R1 lo1 global", rd_lo1, mk_lo(20'h444, 3'd5, 1, 1, 1));
      rd_index = 5'd2; #1;
      chk(rd_pmask === mk_pm(19'h3), "R1 mask image", rd_pmask, mk_pm(19'h3));
      rd_index = 5'd3; #1;
      chk(rd_lo0 === mk_lo(20'h888, 3'd0, 0, 0, 0), "R1 global needs both", rd_lo0, mk_lo(20'h888, 3'd0, 0, 0, 0));

      // vector table: R2 R3 R4 R5 R6 R7 R8
      @(negedge clk);
      for (int k = 0; k < 9; k++) begin
         lu_req = 1'b1;
         look(VEC[k].va, VEC[k].asid);
         chk(lu_hit === VEC[k].hit, "R2 R3 R4 lu_hit", lu_hit, VEC[k].hit);
         chk(lu_inval === VEC[k].inval, "R6 lu_inval", lu_inval, VEC[k].inval);
         chk(lu_multi === VEC[k].multi, "R7 lu_multi", lu_multi, VEC[k].multi);
         chk(lu_pfn === VEC[k].pfn, "R6 lu_pfn", lu_pfn, VEC[k].pfn);
         chk($unsigned(pr_index) === VEC[k].probe, "R5 pr_index", pr_index, VEC[k].probe);
         @(posedge clk);
         @(negedge clk);
         chk(lu_hit_q === VEC[k].hit && lu_miss_q === !VEC[k].hit, "R8 registered",
             {lu_hit_q, lu_miss_q}, {VEC[k].hit, !VEC[k].hit});
      end
      lu_req = 1'b0;
      @(negedge clk);
      chk(!lu_hit_q && !lu_miss_q, "R8 idle", {lu_hit_q, lu_miss_q}, 0);

      // R6 attribute and dirty of the odd half
      look(32'h0004_1000, 8'd7);
      chk(lu_attr === 3'd5 && lu_dirty === 1'b1, "R6 attr dirty", {lu_attr, lu_dirty}, {3'd5, 1'b1});

      // R9 out-of-range write
      put(5'd16, mk_hi(19'h40, 8'd5), mk_pm(19'h0), mk_lo(20'hABC, 3'd0, 0, 1, 0), mk_lo(20'hABD, 3'd0, 0, 1, 0));
      look(32'h0008_0000, 8'd5);
      chk(!lu_hit && pr_index === 5'h1F, "R9 no new mapping", {lu_hit, pr_index}, 5'h1F);
      rd_index = 5'd0; #1;
      chk(rd_hi === mk_hi(19'h10, 8'd5), "R9 slot0 intact", rd_hi, mk_hi(19'h10, 8'd5));

      // R4 overwrite replaces old contents
      put(5'd0, mk_hi(19'h40, 8'd5), mk_pm(19'h0), mk_lo(20'hABC, 3'd0, 0, 1, 0), mk_lo(20'hABD, 3'd0, 0, 1, 0));
      look(32'h0002_0000, 8'd5);
      chk(!lu_hit && !lu_inval, "R4 old mapping gone", {lu_hit, lu_inval}, 0);
      look(32'h0008_0000, 8'd5);
      chk(lu_hit && lu_pfn === 20'hABC && pr_index === 5'd0, "R4 new mapping", lu_pfn, 20'hABC);

      // R12 uncached window
      look(32'hA000_0000, 8'd0);
      chk(lu_uncached === 1'b1, "R12 A0000000", lu_uncached, 1);
      look(32'hE000_1000, 8'd0);
      chk(lu_uncached === 1'b1, "R12 E0001000", lu_uncached, 1);
      look(32'h8000_0000, 8'd0);
      chk(lu_uncached === 1'b0, "R12 80000000", lu_uncached, 0);
      look(32'h2000_0000, 8'd0);
      chk(lu_uncached === 1'b0, "R12 20000000", lu_uncached, 0);

      // R13 mode decode
      status = 32'h0000_0000; #1; chk(mode === 2'b00, "R13 field00", mode, 0);
      status = 32'h0000_0008; #1; chk(mode === 2'b01, "R13 super", mode, 1);
      status = 32'h0000_0010; #1; chk(mode === 2'b10, "R13 user", mode, 2);
      status = 32'h0000_0018; #1; chk(mode === 2'b11, "R13 invalid", mode, 3);
      status = 32'h1000_0010; #1; chk(mode === 2'b00, "R13 bit28", mode, 0);
      status = 32'h0000_0012; #1; chk(mode === 2'b00, "R13 bit1", mode, 0);
      status = 32'h0000_000C; #1; chk(mode === 2'b00, "R13 bit2", mode, 0);
      status = 32'h0;

      // R11 pointer stepping and wrap
      @(negedge clk);
      adv(3);
      chk(rp_index === 4'd3, "R11 step", rp_index, 3);
      adv(12);
      chk(rp_index === 4'd15, "R11 top", rp_index, 15);
      adv(1);
      chk(rp_index === 4'd0, "R11 wrap", rp_index, 0);
      adv(2);

      // R10 flush beats a same-cycle write
      flush = 1'b1;
      wr_en = 1'b1; wr_index = 5'd4; wr_hi = mk_hi(19'h50, 8'd1); wr_pmask = '0;
      wr_lo0 = mk_lo(20'h123, 3'd0, 0, 1, 0); wr_lo1 = mk_lo(20'h124, 3'd0, 0, 1, 0);
      @(negedge clk);
      flush = 1'b0; wr_en = 1'b0;
      chk(rp_index === 4'd0, "R10 pointer", rp_index, 0);
      rd_index = 5'd4; #1;
      chk(rd_hi === 30'h0 && rd_lo0 === 26'h0, "R10 write dropped", {rd_hi, rd_lo0}, 0);
      rd_index = 5'd1; #1;
      chk(rd_hi === 30'h0 && rd_lo1 === 26'h0, "R10 slot1 cleared", {rd_hi, rd_lo1}, 0);
      look(32'h0004_0000, 8'd7);
      chk(!lu_hit && pr_index === 5'h1F, "R10 no match", {lu_hit, pr_index}, 5'h1F);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule